// File: doc/BRIEF.md
# Serial Port Control/Status Register and Interrupt Block

This block is the register face of a simple byte-wide serial port. It sits on a 32-bit word-addressed register bus with separate read and write strobes. It holds the control words, the interrupt mask, a self-clearing acknowledge register, and the raw and masked interrupt vectors. It drives one level-sensitive interrupt line. The bit-level line engine, the baud timing and DMA are outside this block.

Outbound bytes leave on a valid/ready stream. A write to the data-out word loads a holding stage. That stage keeps `tx_valid` high and `tx_data` steady until a cycle in which `tx_ready` is also high. If a new data-out write arrives while a byte is still waiting, the waiting byte is replaced. Inbound bytes arrive on a valid/ready stream too. A byte is taken only in a cycle where `rx_valid` and `rx_ready` are both high. `rx_ready` may drop while the receiver's previous byte is still flagged. The sender must then hold the byte, because a byte offered while `rx_ready` is low is not captured.

Every write and every accepted byte updates the interrupt state in one step. The bits set by the event are merged into the raw vector, and the acknowledge value clears the bits it names. The masked vector is the raw vector ANDed with the mask. A pending-transmit flag makes the first acknowledge of the transmit bit after a data-out write leave that bit set.

Top module: `serp_top`

## Requirements
- R1: After reset, every readable word is zero except the status word, which reads 0x00C00000 (bit 22 idle, bit 23 transmitter ready). `irq` and `tx_valid` are low.
- R2: A read strobe returns the addressed word on `bus_rdata` on the clock after the strobe. The words are: 0 tx control, 1 tx DMA enable, 2 rx control, 7 data out, 8 status with read clear, 9 status without side effect, 11 mask, 12 acknowledge, 13 raw interrupt, 14 masked interrupt. Words 0, 1, 2 and 11 read back what was last written. Every unmapped word reads zero, and writes to unmapped words have no effect.
- R3: A write to word 7 does four things: it stores the full value, presents bits 7:0 on `tx_data` with `tx_valid` high from the next cycle, sets raw bit 0, and sets the pending-transmit flag. `tx_valid` and `tx_data` hold until a cycle with `tx_ready` high; after that cycle `tx_valid` is low.
- R4: An accepted byte writes status bits 7:0 with the byte and sets status bit 16 (data available) and raw bit 3.
- R5: Reading word 8 returns the status word and clears status bit 16. Reading word 9 returns the same word and changes nothing.
- R6: A write to word 12 clears each raw bit whose acknowledge bit is 1. Word 12 always reads zero.
- R7: An acknowledge with bit 0 set while pending-transmit is set leaves raw bit 0 set and clears pending-transmit. The next such acknowledge clears raw bit 0.
- R8: Word 14 reads raw AND mask. `irq` is high exactly when that AND is non-zero, and it follows any write or accepted byte on the next cycle.
- R9: `rx_ready` is high when rx control bit 0 is set or raw bit 3 is clear.
- R10: Writes to words 8, 9, 13 and 14 change no state.
- R11: When a byte is accepted in the same cycle as a read of word 8 or an acknowledge of bit 3, the byte wins. Status bit 16 and raw bit 3 end up set, and the read returns the status word from before the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| tx_data | output | 8 | Outbound byte |
| tx_valid | output | 1 | Outbound byte valid |
| tx_ready | input | 1 | Downstream accepts the byte |
| rx_data | input | 8 | Inbound byte |
| rx_valid | input | 1 | Inbound byte valid |
| rx_ready | output | 1 | Block can take an inbound byte |
| irq | output | 1 | Level interrupt |

## Verification
The bound checker watches these on every cycle:
- `irq` matches the registered raw and mask vectors.
- An accepted byte always leaves data-available and raw bit 3 set.
- A waiting outbound byte does not move until ready.
- A read-clear access drops the data-available flag.
- The non-clearing alias and writes to the raw offset leave state alone.

Only the bench scenarios can show the following, because they need a sequence of accesses with known values:
- read latency and readback values
- the two-step acknowledge of the transmit bit with the pending flag
- rejection of bytes offered while `rx_ready` is low
- the exact status words returned when a byte collides with a read or an acknowledge

// File: rtl/serp_pkg.sv
`timescale 1ns/1ps
package serp_pkg;
  // word indices on the register bus (the bus behaviour depends on these)
  localparam int unsigned W_TXCTL   = 0;
  localparam int unsigned W_TXDMA   = 1;
  localparam int unsigned W_RXCTL   = 2;
  localparam int unsigned W_DOUT    = 7;
  localparam int unsigned W_STATCLR = 8;
  localparam int unsigned W_STAT    = 9;
  localparam int unsigned W_MASK    = 11;
  localparam int unsigned W_ACK     = 12;
  localparam int unsigned W_RAW     = 13;
  localparam int unsigned W_MSKD    = 14;
  // status bit positions
  localparam int unsigned B_DAV     = 16;
  localparam int unsigned B_IDLE    = 22;
  localparam int unsigned B_TRDY    = 23;
  // interrupt bit positions
  localparam int unsigned I_TX      = 0;
  localparam int unsigned I_RX      = 3;
endpackage

// File: rtl/serp_tx_hold.sv
`timescale 1ns/1ps
module serp_tx_hold #(
  parameter int unsigned BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [BW-1:0] load_byte,
  output logic [BW-1:0] tx_data,
  output logic          tx_valid,
  input  logic          tx_ready
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_data  <= '0;
      tx_valid <= 1'b0;
    end else if (load) begin
      tx_data  <= load_byte;
      tx_valid <= 1'b1;
    end else if (tx_valid && tx_ready) begin
      tx_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/serp_rx_status.sv
`timescale 1ns/1ps
module serp_rx_status #(
  parameter int unsigned DW = 32,
  parameter int unsigned BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [BW-1:0] byte_in,
  input  logic          clr_dav,
  output logic          dav,
  output logic [DW-1:0] status
);
  import serp_pkg::*;
  logic [BW-1:0] last_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_byte <= '0;
      dav       <= 1'b0;
    end else begin
      if (take) last_byte <= byte_in;
      if (take)         dav <= 1'b1;
      else if (clr_dav) dav <= 1'b0;
    end
  end

  always_comb begin
    status          = '0;
    status[BW-1:0]  = last_byte;
    status[B_DAV]   = dav;
    status[B_IDLE]  = 1'b1;
    status[B_TRDY]  = 1'b1;
  end
endmodule

// File: rtl/serp_irq_core.sv
`timescale 1ns/1ps
module serp_irq_core #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_load,
  input  logic          ack_wr,
  input  logic [DW-1:0] ack_val,
  input  logic          mask_wr,
  input  logic [DW-1:0] mask_val,
  input  logic          rx_take,
  output logic [DW-1:0] raw,
  output logic [DW-1:0] mask,
  output logic          irq
);
  import serp_pkg::*;
  logic          pending;
  logic          ack_hit;
  logic [DW-1:0] ack_eff, set_v, raw_n, mask_n;
  logic          pend_n;

  always_comb begin
    ack_hit = ack_wr && pending && ack_val[I_TX];
    ack_eff = ack_wr ? ack_val : '0;
    if (ack_hit) ack_eff[I_TX] = 1'b0;
    set_v        = '0;
    set_v[I_TX]  = tx_load || ack_hit;
    raw_n        = (raw | set_v) & ~ack_eff;
    if (rx_take) raw_n[I_RX] = 1'b1;
    mask_n = mask_wr ? mask_val : mask;
    if (tx_load)      pend_n = 1'b1;
    else if (ack_hit) pend_n = 1'b0;
    else              pend_n = pending;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw     <= '0;
      mask    <= '0;
      pending <= 1'b0;
      irq     <= 1'b0;
    end else begin
      raw     <= raw_n;
      mask    <= mask_n;
      pending <= pend_n;
      irq     <= |(raw_n & mask_n);
    end
  end
endmodule

// File: rtl/serp_top.sv
`timescale 1ns/1ps
module serp_top #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 32,
  parameter int unsigned BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [BW-1:0] tx_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  input  logic [BW-1:0] rx_data,
  input  logic          rx_valid,
  output logic          rx_ready,
  output logic          irq
);
  import serp_pkg::*;

  logic [DW-1:0] txctl_q, txdma_q, rxctl_q, dout_q;
  logic [DW-1:0] irq_raw, irq_mask, status_w, rd_mux;
  logic          stat_dav, rx_take;
  logic          wr_txctl, wr_txdma, wr_rxctl, wr_dout, wr_mask, wr_ack, rd_clr;

  assign wr_txctl = bus_wr && (bus_addr == AW'(W_TXCTL));
  assign wr_txdma = bus_wr && (bus_addr == AW'(W_TXDMA));
  assign wr_rxctl = bus_wr && (bus_addr == AW'(W_RXCTL));
  assign wr_dout  = bus_wr && (bus_addr == AW'(W_DOUT));
  assign wr_mask  = bus_wr && (bus_addr == AW'(W_MASK));
  assign wr_ack   = bus_wr && (bus_addr == AW'(W_ACK));
  assign rd_clr   = bus_rd && (bus_addr == AW'(W_STATCLR));

  assign rx_ready = rxctl_q[0] || !irq_raw[I_RX];
  assign rx_take  = rx_valid && rx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txctl_q <= '0;
      txdma_q <= '0;
      rxctl_q <= '0;
      dout_q  <= '0;
    end else begin
      if (wr_txctl) txctl_q <= bus_wdata;
      if (wr_txdma) txdma_q <= bus_wdata;
      if (wr_rxctl) rxctl_q <= bus_wdata;
      if (wr_dout)  dout_q  <= bus_wdata;
    end
  end

  serp_tx_hold #(.BW(BW)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(wr_dout), .load_byte(bus_wdata[BW-1:0]),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready)
  );

  serp_rx_status #(.DW(DW), .BW(BW)) u_rx (
    .clk(clk), .rst_n(rst_n), .take(rx_take), .byte_in(rx_data),
    .clr_dav(rd_clr), .dav(stat_dav), .status(status_w)
  );

  serp_irq_core #(.DW(DW)) u_irq (
    .clk(clk), .rst_n(rst_n), .tx_load(wr_dout), .ack_wr(wr_ack),
    .ack_val(bus_wdata), .mask_wr(wr_mask), .mask_val(bus_wdata),
    .rx_take(rx_take), .raw(irq_raw), .mask(irq_mask), .irq(irq)
  );

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      AW'(W_TXCTL):   rd_mux = txctl_q;
      AW'(W_TXDMA):   rd_mux = txdma_q;
      AW'(W_RXCTL):   rd_mux = rxctl_q;
      AW'(W_DOUT):    rd_mux = dout_q;
      AW'(W_STATCLR): rd_mux = status_w;
      AW'(W_STAT):    rd_mux = status_w;
      AW'(W_MASK):    rd_mux = irq_mask;
      AW'(W_RAW):     rd_mux = irq_raw;
      AW'(W_MSKD):    rd_mux = irq_raw & irq_mask;
      default:        rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/serp_chk.sv
`timescale 1ns/1ps
module serp_chk #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 32,
  parameter int unsigned BW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [DW-1:0] bus_wdata,
  input logic [BW-1:0] tx_data,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic          irq,
  input logic [DW-1:0] raw,
  input logic [DW-1:0] mask,
  input logic          dav
);
  logic rx_acc, dout_wr;
  assign rx_acc  = rx_valid && rx_ready;
  assign dout_wr = bus_wr && (bus_addr == AW'(7));

  // R8
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(raw & mask));

  // R4
  rx_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_acc |=> (dav && raw[3]));

  // R3
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !dout_wr) |=> (tx_valid && $stable(tx_data)));

  // R3
  tx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_wr |=> (tx_valid && tx_data == $past(bus_wdata[BW-1:0]) && raw[0]));

  // R5
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == AW'(8) && !rx_acc) |=> !dav);

  // R5
  rd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == AW'(9) && !rx_acc) |=> $stable(dav));

  // R10
  raw_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(13) && !rx_acc) |=> $stable(raw));
endmodule

bind serp_top serp_chk #(.AW(AW), .DW(DW), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_wdata(bus_wdata), .tx_data(tx_data),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .irq(irq), .raw(irq_raw), .mask(irq_mask),
  .dav(stat_dav)
);

// File: tb/serp_top_test.sv
`timescale 1ns/1ps
module serp_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  serp_top uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic send(input logic [7:0] b);
    rx_data = b; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(4'd9, d);  chk("R1 status", d, 32'h00C00000);
    rd(4'd0, d);  chk("R1 txctl", d, 32'h0);
    rd(4'd13, d); chk("R1 raw", d, 32'h0);
    rd(4'd11, d); chk("R1 mask", d, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 tx_valid", {31'b0, tx_valid}, 32'h0);
  endtask

  task automatic t_ctrl;
    logic [31:0] d;
    wr(4'd0, 32'h12345678);
    rd(4'd0, d);  chk("R2 txctl readback", d, 32'h12345678);
    wr(4'd1, 32'h000000A5);
    rd(4'd1, d);  chk("R2 dma readback", d, 32'h000000A5);
    wr(4'd2, 32'h00000010);
    rd(4'd2, d);  chk("R2 rxctl readback", d, 32'h00000010);
    wr(4'd3, 32'hFFFFFFFF);
    rd(4'd3, d);  chk("R2 unmapped zero", d, 32'h0);
    wr(4'd12, 32'h000000F0);
    rd(4'd12, d); chk("R6 ack reads zero", d, 32'h0);
  endtask

  task automatic t_tx;
    logic [31:0] d;
    tx_ready = 1'b0;
    wr(4'd7, 32'h000001A5);
    chk("R3 tx_valid", {31'b0, tx_valid}, 32'h1);
    chk("R3 tx_data", {24'b0, tx_data}, 32'hA5);
    repeat (3) @(negedge clk);
    chk("R3 held valid", {31'b0, tx_valid}, 32'h1);
    chk("R3 held data", {24'b0, tx_data}, 32'hA5);
    rd(4'd13, d); chk("R3 raw bit0", d, 32'h1);
    rd(4'd7, d);  chk("R3 dout stored", d, 32'h000001A5);
    tx_ready = 1'b1;
    @(negedge clk);
    chk("R3 drained", {31'b0, tx_valid}, 32'h0);
  endtask

  task automatic t_ack;
    logic [31:0] d;
    wr(4'd12, 32'h1);
    rd(4'd13, d); chk("R7 pending keeps bit0", d, 32'h1);
    wr(4'd12, 32'h1);
    rd(4'd13, d); chk("R7 second ack clears", d, 32'h0);
    rd(4'd12, d); chk("R6 ack zero", d, 32'h0);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    wr(4'd11, 32'h1);
    chk("R8 irq low", {31'b0, irq}, 32'h0);
    wr(4'd7, 32'h00000042);
    chk("R8 irq high", {31'b0, irq}, 32'h1);
    rd(4'd14, d); chk("R8 masked", d, 32'h1);
    wr(4'd11, 32'h0);
    chk("R8 irq masked off", {31'b0, irq}, 32'h0);
    rd(4'd14, d); chk("R8 masked zero", d, 32'h0);
    rd(4'd13, d); chk("R8 raw kept", d, 32'h1);
    wr(4'd11, 32'h1);
    chk("R8 irq back", {31'b0, irq}, 32'h1);
    wr(4'd12, 32'h1);
    chk("R7 irq stays", {31'b0, irq}, 32'h1);
    wr(4'd12, 32'h1);
    chk("R6 irq cleared", {31'b0, irq}, 32'h0);
    wr(4'd11, 32'h8);
  endtask

  task automatic t_rx;
    logic [31:0] d;
    chk("R9 ready idle", {31'b0, rx_ready}, 32'h1);
    send(8'h3C);
    chk("R4 irq rx", {31'b0, irq}, 32'h1);
    chk("R9 not ready", {31'b0, rx_ready}, 32'h0);
    rd(4'd9, d); chk("R4 status", d, 32'h00C1003C);
    rd(4'd9, d); chk("R5 alias no clear", d, 32'h00C1003C);
    rd(4'd8, d); chk("R5 clearing read", d, 32'h00C1003C);
    rd(4'd9, d); chk("R5 dav cleared", d, 32'h00C0003C);
    chk("R5 irq unaffected", {31'b0, irq}, 32'h1);
    wr(4'd12, 32'h8);
    rd(4'd13, d); chk("R6 raw bit3 cleared", d, 32'h0);
    chk("R9 ready again", {31'b0, rx_ready}, 32'h1);
  endtask

  task automatic t_ready;
    logic [31:0] d;
    send(8'h11);
    send(8'h22);
    rd(4'd9, d); chk("R9 byte refused", d, 32'h00C10011);
    wr(4'd2, 32'h1);
    chk("R9 ctrl forces ready", {31'b0, rx_ready}, 32'h1);
    send(8'h22);
    rd(4'd9, d); chk("R9 byte taken", d, 32'h00C10022);
    wr(4'd12, 32'h8);
    rd(4'd8, d);
    wr(4'd2, 32'h0);
  endtask

  task automatic t_ignored;
    logic [31:0] d;
    wr(4'd13, 32'hFFFFFFFF);
    rd(4'd13, d); chk("R10 raw write ignored", d, 32'h0);
    wr(4'd14, 32'hFFFFFFFF);
    rd(4'd14, d); chk("R10 masked write ignored", d, 32'h0);
    wr(4'd9, 32'h000000FF);
    wr(4'd8, 32'h000000FF);
    rd(4'd9, d); chk("R10 status write ignored", d, 32'h00C00022);
    chk("R10 irq low", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    rx_data = 8'h5A; rx_valid = 1'b1;
    bus_addr = 4'd8; bus_rd = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; bus_rd = 1'b0;
    chk("R11 read sees old", bus_rdata, 32'h00C00022);
    rd(4'd9, d); chk("R11 byte beats clear", d, 32'h00C1005A);
    wr(4'd2, 32'h1);
    rx_data = 8'h6B; rx_valid = 1'b1;
    bus_addr = 4'd12; bus_wdata = 32'h8; bus_wr = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; bus_wr = 1'b0;
    rd(4'd13, d); chk("R11 byte beats ack", d, 32'h8);
    rd(4'd9, d);  chk("R11 status", d, 32'h00C1006B);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_tx();
    t_ack();
    t_irq();
    t_rx();
    t_ready();
    t_ignored();
    t_collide();
    finish_run();
  end
endmodule